// File: doc/BRIEF.md
# Receive Character Queue with Ready, Interrupt and DMA Gating

This block sits between a serial receiver's shift register and the host side of a UART. Each completed character arrives with a one-cycle valid strobe, its 8 data bits and three per-character error indications: parity, framing and overrun. The block holds up to four characters. It shows the oldest one on a read-data port, and a host read strobe removes it. The queue is there only to give the host time, so that bursts do not overrun.

A ready flag stays high while any character is held. Interrupts or DMA turn that flag into a request. When DMA is enabled it replaces the interrupt. The DMA request is withheld while any error flag is set, so the host handles the faulty character before the transfer goes on. The error flags are sticky and are cleared only by an explicit clear pulse.

The input side follows valid/ready. `in_ready` is low while the queue is full. A producer that cannot stall may still assert `in_valid`; that character is then dropped and counted as an overrun. The output side is a read strobe. `data_ready` plays the role of valid, and `rd_en` pops only when `data_ready` is high.

Top module: `rx_char_queue`

## Requirements
- R1: `data_ready` is 1 exactly while the queue holds at least one character; a character accepted on a clock edge (`in_valid` and `in_ready`) makes it 1 from that edge on.
- R2: Characters leave in arrival order, and the queue holds `DEPTH` (default 4) of them. `rd_data` shows the oldest held character, and `rd_en` with `data_ready` high removes it on the clock edge.
- R3: While the queue is full, `in_ready` is 0, a character offered with `in_valid` is discarded (a read in the same cycle does not rescue it), and `err_ovr` becomes 1 on that edge.
- R4: `rd_en` while the queue is empty changes no state. In that case `rd_data` shows the last character removed, or 0 if none has been removed since reset.
- R5: A read that leaves further characters in the queue keeps `data_ready` (and any enabled request) high with no gap.
- R6: `irq` = `data_ready` AND `irq_en` AND NOT `dma_en`.
- R7: `dma_req` = `data_ready` AND `dma_en` AND none of `err_par`, `err_frm`, `err_ovr`.
- R8: Each stored character keeps its own parity and framing bits. On the edge where a character becomes the oldest held one, its parity bit ORs into `err_par` and its framing bit ORs into `err_frm`.
- R9: A character offered with `in_valid` and `in_ovr_err` high sets `err_ovr`, whether it is stored or discarded.
- R10: The error flags stay set through reads and are cleared only by `err_clr`. A flag-setting event on the same edge as `err_clr` wins.
- R11: After reset the queue is empty, all flags and requests are 0, `rd_data` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character from shift register is valid this cycle |
| in_ready | output | 1 | Queue can store a character (not full) |
| in_data | input | 8 | Received character |
| in_par_err | input | 1 | Parity error for this character |
| in_frm_err | input | 1 | Framing error for this character |
| in_ovr_err | input | 1 | Receiver overrun reported with this character |
| rd_en | input | 1 | Host read strobe (pop) |
| rd_data | output | 8 | Oldest held character, or last removed one when empty |
| data_ready | output | 1 | At least one character held |
| err_par | output | 1 | Sticky parity error flag |
| err_frm | output | 1 | Sticky framing error flag |
| err_ovr | output | 1 | Sticky overrun flag |
| err_clr | input | 1 | Clear all error flags |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA enable |
| irq | output | 1 | Receive interrupt request |
| dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that every input is a known 0 or 1 on each rising edge. They also assume the error bits matter only in a cycle where `in_valid` is high, and that `rd_en` may arrive at any time, including on an empty queue. The stimulus changes inputs only on falling edges and draws each bit at random, with rates that change per phase. Some phases push the queue into overflow, some drain it into empty reads, and some run DMA with and without errors pending, so that each assumed input pattern is reached.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int RXQ_DATA_W = 8;

  typedef struct packed {
    logic                  par;
    logic                  frm;
    logic [RXQ_DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  rxq_entry_t                 wr_entry,
  output rxq_entry_t                 head,
  output rxq_entry_t                 next_head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t      slots [DEPTH];
  logic [PW-1:0]   wr_ptr;
  logic [PW-1:0]   rd_ptr;
  logic [CW-1:0]   cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[i] <= '0;
      end else if (push && (wr_ptr == PW'(i))) begin
        slots[i] <= wr_entry;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head      = slots[rd_ptr];
  assign next_head = slots[rd_ptr + PW'(1)];
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic head_set,
  input  logic head_par,
  input  logic head_frm,
  input  logic ovr_set,
  output logic flag_par,
  output logic flag_frm,
  output logic flag_ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_par <= 1'b0;
      flag_frm <= 1'b0;
      flag_ovr <= 1'b0;
    end else begin
      flag_par <= (flag_par & ~clr) | (head_set & head_par);
      flag_frm <= (flag_frm & ~clr) | (head_set & head_frm);
      flag_ovr <= (flag_ovr & ~clr) | ovr_set;
    end
  end
endmodule

// File: rtl/rxq_req.sv
module rxq_req (
  input  logic ready,
  input  logic irq_en,
  input  logic dma_en,
  input  logic any_err,
  output logic irq,
  output logic dma_req
);
  always_comb begin
    irq     = ready & irq_en & ~dma_en;
    dma_req = ready & dma_en & ~any_err;
  end
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [RXQ_DATA_W-1:0] in_data,
  input  logic                  in_par_err,
  input  logic                  in_frm_err,
  input  logic                  in_ovr_err,
  input  logic                  rd_en,
  output logic [RXQ_DATA_W-1:0] rd_data,
  output logic                  data_ready,
  output logic                  err_par,
  output logic                  err_frm,
  output logic                  err_ovr,
  input  logic                  err_clr,
  input  logic                  irq_en,
  input  logic                  dma_en,
  output logic                  irq,
  output logic                  dma_req
);
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t      wr_entry;
  rxq_entry_t      head;
  rxq_entry_t      next_head;
  rxq_entry_t      arriving_head;
  logic [CW-1:0]   count;
  logic            full;
  logic            empty;
  logic            push;
  logic            pop;
  logic            head_set;
  logic            ovr_set;
  logic [RXQ_DATA_W-1:0] last_data;

  assign wr_entry = '{par: in_par_err, frm: in_frm_err, data: in_data};
  assign push     = in_valid & ~full;
  assign pop      = rd_en & ~empty;

  // a character becomes the oldest one: either the second moves up,
  // or the arriving one lands in an empty (or emptying) queue
  always_comb begin
    head_set      = 1'b0;
    arriving_head = wr_entry;
    if (pop && (count > CW'(1))) begin
      head_set      = 1'b1;
      arriving_head = next_head;
    end else if (push && (empty || (pop && (count == CW'(1))))) begin
      head_set      = 1'b1;
      arriving_head = wr_entry;
    end
  end

  assign ovr_set = in_valid & (in_ovr_err | full);

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .pop       (pop),
    .wr_entry  (wr_entry),
    .head      (head),
    .next_head (next_head),
    .count     (count),
    .full      (full),
    .empty     (empty)
  );

  rxq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (err_clr),
    .head_set (head_set),
    .head_par (arriving_head.par),
    .head_frm (arriving_head.frm),
    .ovr_set  (ovr_set),
    .flag_par (err_par),
    .flag_frm (err_frm),
    .flag_ovr (err_ovr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_data <= '0;
    end else if (pop) begin
      last_data <= head.data;
    end
  end

  assign data_ready = ~empty;
  assign in_ready   = ~full;
  assign rd_data    = empty ? last_data : head.data;

  rxq_req u_req (
    .ready   (data_ready),
    .irq_en  (irq_en),
    .dma_en  (dma_en),
    .any_err (err_par | err_frm | err_ovr),
    .irq     (irq),
    .dma_req (dma_req)
  );
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_ovr_err,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       data_ready,
  input logic       err_par,
  input logic       err_frm,
  input logic       err_ovr,
  input logic       err_clr,
  input logic       irq,
  input logic       dma_req
);
  assert_accept_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> data_ready);

  assert_no_pop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rd_en) |=> data_ready);

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> err_ovr);

  assert_ovr_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ovr_err) |=> err_ovr);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && rd_en && !in_valid) |=> ($stable(rd_data) && !data_ready));

  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !dma_req);

  assert_dma_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par || err_frm || err_ovr) |-> !dma_req);

  assert_sticky_par_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_par && !err_clr) |=> err_par);

  assert_sticky_frm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frm && !err_clr) |=> err_frm);
endmodule

bind rx_char_queue rx_char_queue_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_ovr_err (in_ovr_err),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .data_ready (data_ready),
  .err_par    (err_par),
  .err_frm    (err_frm),
  .err_ovr    (err_ovr),
  .err_clr    (err_clr),
  .irq        (irq),
  .dma_req    (dma_req)
);

// File: tb/rx_char_queue_test.sv
`timescale 1ns/1ps
module rx_char_queue_test;
  localparam int QD = 4;

  typedef struct {
    int       id;
    bit [7:0] d;
    bit       p;
    bit       f;
  } mchar_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_par_err = 1'b0, in_frm_err = 1'b0, in_ovr_err = 1'b0;
  logic [7:0] in_data = '0;
  logic       rd_en = 1'b0, err_clr = 1'b0, irq_en = 1'b0, dma_en = 1'b0;
  logic       in_ready, data_ready, err_par, err_frm, err_ovr, irq, dma_req;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  mchar_t   q[$];
  int       next_id = 0;
  bit [7:0] m_last = '0;
  bit       m_par = 0, m_frm = 0, m_ovr = 0;

  always #2 clk = ~clk;

  rx_char_queue #(.DEPTH(QD)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par_err(in_par_err), .in_frm_err(in_frm_err),
    .in_ovr_err(in_ovr_err), .rd_en(rd_en), .rd_data(rd_data),
    .data_ready(data_ready), .err_par(err_par), .err_frm(err_frm),
    .err_ovr(err_ovr), .err_clr(err_clr), .irq_en(irq_en), .dma_en(dma_en),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit       e_rdy = (q.size() > 0);
    bit [7:0] e_dat = e_rdy ? q[0].d : m_last;
    bit       e_any = m_par | m_frm | m_ovr;
    check(data_ready == e_rdy, "R1/R5 data_ready", data_ready, e_rdy);
    check(rd_data == e_dat, "R2/R4 rd_data", rd_data, e_dat);
    check(in_ready == (q.size() < QD), "R3 in_ready", in_ready, q.size() < QD);
    check(irq == (e_rdy & irq_en & ~dma_en), "R6 irq", irq, e_rdy & irq_en & ~dma_en);
    check(dma_req == (e_rdy & dma_en & ~e_any), "R7 dma_req", dma_req, e_rdy & dma_en & ~e_any);
    check(err_par == m_par, "R8/R10 err_par", err_par, m_par);
    check(err_frm == m_frm, "R8/R10 err_frm", err_frm, m_frm);
    check(err_ovr == m_ovr, "R3/R9 err_ovr", err_ovr, m_ovr);
  endtask

  // behavioural next state from the current inputs
  task automatic model_step();
    bit was_full = (q.size() == QD);
    int old_id   = (q.size() > 0) ? q[0].id : -1;
    if (err_clr) begin
      m_par = 0; m_frm = 0; m_ovr = 0;
    end
    if (in_valid && (in_ovr_err || was_full)) m_ovr = 1;
    if (rd_en && q.size() > 0) begin
      m_last = q[0].d;
      void'(q.pop_front());
    end
    if (in_valid && !was_full) begin
      q.push_back('{id: next_id, d: in_data, p: in_par_err, f: in_frm_err});
      next_id++;
    end
    if (q.size() > 0 && q[0].id != old_id) begin
      m_par |= q[0].p;
      m_frm |= q[0].f;
    end
  endtask

  task automatic run(int cycles, int pv, int pr, int perr, int pclr, int pie, int pde);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid   = ($urandom_range(99) < pv);
      in_data    = 8'($urandom);
      in_par_err = ($urandom_range(99) < perr);
      in_frm_err = ($urandom_range(99) < perr);
      in_ovr_err = ($urandom_range(99) < perr);
      rd_en      = ($urandom_range(99) < pr);
      err_clr    = ($urandom_range(99) < pclr);
      irq_en     = ($urandom_range(99) < pie);
      dma_en     = ($urandom_range(99) < pde);
      #1;
      compare_all();
      model_step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(data_ready == 0, "R11 data_ready", data_ready, 0);
    check(rd_data == 0, "R11 rd_data", rd_data, 0);
    check(in_ready == 1, "R11 in_ready", in_ready, 1);
    check({err_par, err_frm, err_ovr, irq, dma_req} == 0, "R11 flags",
          {err_par, err_frm, err_ovr, irq, dma_req}, 0);
    rst_n = 1'b1;
    run(6, 0, 100, 0, 0, 100, 0);        // R4 reads on empty after reset
    run(10, 100, 0, 0, 0, 100, 0);       // R3 fill and overflow
    run(10, 0, 100, 0, 0, 100, 0);       // R2 drain in order, then R4
    run(4, 0, 0, 0, 100, 0, 0);
    run(800, 50, 50, 10, 5, 60, 30);
    run(600, 85, 20, 8, 10, 50, 50);
    run(600, 20, 85, 8, 10, 50, 50);
    run(600, 60, 60, 3, 30, 20, 90);     // R7 DMA with frequent clears
    run(300, 60, 60, 0, 100, 0, 100);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule